// File: doc/BRIEF.md
# Read-Modify-Write Delay Chain

This block is a small timing chain that runs beside the main cycle sequencer of a processor core and serves the read-modify-write instructions. The instruction decoder sends a one-cycle start pulse, in a cycle that depends on the addressing mode. The start comes in the second cycle of the instruction for zero page and in the third for zero-page indexed and absolute. It comes in the fourth for absolute indexed and in the fifth for the two indirect modes. The chain then walks through two stage cycles, first and second. While in the second stage it raises an end request, which makes the sequencer enter its final-minus-one state on the following cycle.

The chain is not cleared by a sensed processor reset. It keeps propagating through a reset abort, so a late end request can still reach the sequencer after reset has already forced the fetch state. This can inject an extra end-and-fetch pair. The first stage also causes a write request toward the memory bus, which appears one cycle after that stage. It is suppressed when reset-forced read-only mode is in effect, or when a reset was sensed in the cycle that produced it.

States: `CH_IDLE`, `CH_SD1`, `CH_SD2`. Transitions:
- any state to `CH_SD1` on a start pulse (restart);
- `CH_SD1` to `CH_SD2` without a start;
- `CH_SD2` to `CH_IDLE` without a start;
- `CH_IDLE` stays idle without a start.

Top module: `rmw_delay_chain`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `sd1`, `sd2`, `end_req` and `wr_req` are all 0.
- R2: A start pulse (`init_pulse`=1) in cycle N makes `sd1`=1 in cycle N+1.
- R3: With no new start in cycle N+1, `sd2`=1 and `sd1`=0 in cycle N+2.
- R4: `sd1` and `sd2` are never 1 in the same cycle.
- R5: `end_req` is 1 exactly in the cycles where the chain is in its second stage, that is, the cycle before the sequencer is forced to its end state.
- R6: After the second stage, with no start, the chain returns to idle: `sd1`=`sd2`=`end_req`=0.
- R7: A start pulse while the chain is in either stage restarts it: the next cycle has `sd1`=1 and `sd2`=0.
- R8: `res_sensed` has no effect on the stage sequence or on `end_req`. The chain keeps propagating through a reset abort.
- R9: `wr_req`=1 in cycle M+1 when `sd1`=1 in cycle M, `res_sensed`=0 in cycle M, and `rd_only`=0 in cycle M+1; otherwise `wr_req`=0.
- R10: `rd_only`=1 forces `wr_req`=0 in the same cycle.
- R11: `res_sensed`=1 in cycle M forces `wr_req`=0 in cycle M+1.
- R12: With no start pulse, an idle chain stays idle indefinitely. This is the terminal state of instructions that never end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low power-on initialisation of the chain flops |
| init_pulse | input | 1 | Decoder start pulse, one cycle, mode-dependent timing |
| res_sensed | input | 1 | Processor reset sensed in this cycle |
| rd_only | input | 1 | Reset-forced read-only mode of the bus |
| sd1 | output | 1 | Chain in its first stage |
| sd2 | output | 1 | Chain in its second stage |
| end_req | output | 1 | Request to force the sequencer to its end state next cycle |
| wr_req | output | 1 | Write request toward the memory bus read/write line |

## Verification
A reset sense can coincide with the chain's first or second stage. In that cycle the chain must keep advancing and still raise its end request, while the write request it would cause one cycle later must be blocked. The bench provokes this by asserting `res_sensed` in the start cycle, the first-stage cycle and the second-stage cycle, and by raising `rd_only` in the write cycle. A queue-based reference model, built from the requirements, predicts every output of every cycle. A restart pulse landing in the same cycle as a stage is also driven, both in directed sequences and in a random stretch.

// File: rtl/rmw_chain_pkg.sv
package rmw_chain_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_SD1  = 2'd1,
        CH_SD2  = 2'd2
    } chain_st_e;

endpackage

// File: rtl/rmw_chain_fsm.sv
module rmw_chain_fsm
    import rmw_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init_pulse,
    output logic stage1,
    output logic stage2,
    output logic end_req
);

    chain_st_e cur_st;
    chain_st_e nxt_st;

    // next-state: a start always wins, so a busy chain restarts at stage one
    always_comb begin
        nxt_st = CH_IDLE;
        unique case (cur_st)
            CH_IDLE: nxt_st = init_pulse ? CH_SD1 : CH_IDLE;
            CH_SD1:  nxt_st = init_pulse ? CH_SD1 : CH_SD2;
            CH_SD2:  nxt_st = init_pulse ? CH_SD1 : CH_IDLE;
            default: nxt_st = CH_IDLE;
        endcase
    end

    // state register; the processor reset sense never reaches this flop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_st <= CH_IDLE;
        else
            cur_st <= nxt_st;
    end

    // outputs decoded from the state
    always_comb begin
        stage1  = 1'b0;
        stage2  = 1'b0;
        end_req = 1'b0;
        unique case (cur_st)
            CH_IDLE: ;
            CH_SD1:  stage1 = 1'b1;
            CH_SD2: begin
                stage2  = 1'b1;
                end_req = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rmw_wr_path.sv
module rmw_wr_path #(
    parameter int WR_DELAY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stage1,
    input  logic res_sensed,
    input  logic rd_only,
    output logic wr_req
);

    localparam int LAST = WR_DELAY - 1;

    logic [LAST:0] wr_pipe;
    logic [LAST:0] blk_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_pipe[0]  <= 1'b0;
            blk_pipe[0] <= 1'b0;
        end else begin
            wr_pipe[0]  <= stage1;
            blk_pipe[0] <= res_sensed;
        end
    end

    generate
        for (genvar g = 1; g < WR_DELAY; g++) begin : g_pipe
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    wr_pipe[g]  <= 1'b0;
                    blk_pipe[g] <= 1'b0;
                end else begin
                    wr_pipe[g]  <= wr_pipe[g-1];
                    blk_pipe[g] <= blk_pipe[g-1] | res_sensed;
                end
            end
        end
    endgenerate

    // read-only mode overrides in the same cycle; a sense blocks the delayed write
    assign wr_req = wr_pipe[LAST] & ~blk_pipe[LAST] & ~rd_only;

endmodule

// File: rtl/rmw_delay_chain.sv
module rmw_delay_chain #(
    parameter int WR_DELAY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_pulse,
    input  logic res_sensed,
    input  logic rd_only,
    output logic sd1,
    output logic sd2,
    output logic end_req,
    output logic wr_req
);

    logic st1;
    logic st2;
    logic ereq;

    rmw_chain_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_pulse (init_pulse),
        .stage1     (st1),
        .stage2     (st2),
        .end_req    (ereq)
    );

    rmw_wr_path #(.WR_DELAY(WR_DELAY)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .stage1     (st1),
        .res_sensed (res_sensed),
        .rd_only    (rd_only),
        .wr_req     (wr_req)
    );

    assign sd1     = st1;
    assign sd2     = st2;
    assign end_req = ereq;

endmodule

// File: rtl/rmw_delay_chain_chk.sv
module rmw_delay_chain_chk (
    input logic clk,
    input logic rst_n,
    input logic init_pulse,
    input logic res_sensed,
    input logic rd_only,
    input logic sd1,
    input logic sd2,
    input logic end_req,
    input logic wr_req
);

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> sd1);

    p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sd1 && !init_pulse) |=> (sd2 && !sd1));

    p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sd1 && sd2));

    p_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sd1 && !init_pulse) |=> end_req);

    p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sd2 && !init_pulse) |=> (!sd1 && !sd2 && !end_req));

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((sd1 || sd2) && init_pulse) |=> (sd1 && !sd2));

    p_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_only && $past(sd1) && !$past(res_sensed)) |-> wr_req);

    p_rdonly_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_only |-> !wr_req);

    p_sense_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(res_sensed) |-> !wr_req);

    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd1 && !sd2 && !init_pulse) |=> (!sd1 && !sd2));

endmodule

bind rmw_delay_chain rmw_delay_chain_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_pulse (init_pulse),
    .res_sensed (res_sensed),
    .rd_only    (rd_only),
    .sd1        (sd1),
    .sd2        (sd2),
    .end_req    (end_req),
    .wr_req     (wr_req)
);

// File: tb/rmw_delay_chain_bench.sv
module rmw_delay_chain_bench;

    typedef struct packed {
        logic sd1;
        logic sd2;
        logic endr;
        logic wr;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_pulse = 1'b0;
    logic res_sensed = 1'b0;
    logic rd_only = 1'b0;
    logic sd1, sd2, end_req, wr_req;

    int n_cmp = 0;
    int n_bad = 0;
    exp_t q[$];

    // reference model state: previous-cycle inputs and stage
    logic m_start = 1'b0;
    logic m_res = 1'b0;
    logic m_sd1 = 1'b0;

    always #10 clk = ~clk;

    rmw_delay_chain u_rmw_delay_chain (
        .clk(clk), .rst_n(rst_n), .init_pulse(init_pulse),
        .res_sensed(res_sensed), .rd_only(rd_only),
        .sd1(sd1), .sd2(sd2), .end_req(end_req), .wr_req(wr_req)
    );

    // driver: apply one cycle of inputs and push the predicted outputs
    task automatic step(input logic st, input logic rs, input logic ro);
        exp_t e;
        @(negedge clk);
        init_pulse = st;
        res_sensed = rs;
        rd_only    = ro;
        if (!rst_n) begin
            e = '0;  // R1
            m_start = 1'b0; m_res = 1'b0; m_sd1 = 1'b0;
        end else begin
            e.sd1  = m_start;                        // R2 R7
            e.sd2  = m_sd1 & ~m_start;               // R3 R4 R6
            e.endr = e.sd2;                          // R5 R8
            e.wr   = m_sd1 & ~m_res & ~ro;           // R9 R10 R11
            m_sd1  = e.sd1;
            m_start = st;
            m_res   = rs;
        end
        q.push_back(e);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: pop one prediction per cycle, compare away from the edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk("R2 R7 sd1", sd1, e.sd1);
                chk("R3 R6 sd2", sd2, e.sd2);
                chk("R5 R8 end_req", end_req, e.endr);
                chk("R9 R10 R11 wr_req", wr_req, e.wr);
                chk("R4 exclusive", sd1 & sd2, 1'b0);
            end
        end
    end

    initial begin
        #3000000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        @(negedge clk); #1 rst_n = 1'b1;
        // R1 first cycle after reset, R12 idle stays idle
        repeat (4) step(1'b0, 1'b0, 1'b0);
        // R2 R3 R5 R6 R9: plain run
        step(1'b1, 1'b0, 1'b0);
        repeat (4) step(1'b0, 1'b0, 1'b0);
        // R10: read-only in the write cycle
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 0);
        // R8: sense in the start cycle; chain still runs and ends
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        // R11: sense in the first-stage cycle blocks the write
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        // R8: sense in the second-stage cycle, end request unaffected
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        // R7: restart during first stage, then during second stage
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        // R7 back-to-back starts
        repeat (5) step(1'b1, 1'b0, 1'b0);
        repeat (3) step(1'b0, 1'b0, 1'b0);
        // mixed stretch across all requirements
        for (int i = 0; i < 400; i++)
            step(($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0),
                 ($urandom_range(0, 4) == 0));
        repeat (3) step(1'b0, 1'b0, 1'b0);
        @(negedge clk); #4;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule